// File: doc/BRIEF.md
# Vector Widening and Broadcast Load Unit

The block fetches one vector-sized value from a byte-wide memory and turns it into a 128-bit result. A request supplies a dynamic byte address, a static offset, a load kind, a signedness flag and the memory size in bytes. The unit forms a 33-bit effective address and checks that the whole access lies inside memory. It then reads the needed bytes one per cycle, in ascending order, through a synchronous read port. From the little-endian bytes it builds the result.

There are three families of load. A full load returns all 16 bytes as they are. A widening load reads 8 bytes as 8-, 16- or 32-bit elements and stretches each one into a lane of twice its width. A broadcast load reads one 8-, 16-, 32- or 64-bit element and repeats it across the vector. An access that would cross the end of memory does not read at all. It returns a one-cycle trap pulse and a zero vector.

A new request is taken only while the unit is idle. The memory returns the byte for a read in the cycle after `mem_rd_en`.

Top module: `vec_load_unit`

## Requirements
- R1: Kind 0 (full load) returns 16 bytes, and byte i of `res_data` (bits 8i+7..8i) is the memory byte at effective address + i.
- R2: Kinds 1, 2 and 3 read 8 bytes as eight 8-bit, four 16-bit or two 32-bit elements. Element i, taken little-endian from the low end, is widened into lane i of twice its width.
- R3: For widening loads, `req_signed`=1 fills the upper half of each lane with the element's top bit, and `req_signed`=0 fills it with zeros.
- R4: Kinds 4, 5, 6 and 7 read one 8-, 16-, 32- or 64-bit element at the effective address and copy it into every lane of that width.
- R5: The effective address is `req_addr` + `req_offset` computed in 33 bits with no wraparound.
- R6: A trap is raised when effective address + access length exceeds `mem_size`. An access that ends exactly at `mem_size` is legal.
- R7: On a trap, `res_trap` is high for one cycle with `res_valid` low and `res_data` zero, and no memory read is issued.
- R8: A legal access issues exactly as many reads as its length (16, 8, 8, 8, 1, 2, 4, 8 for kinds 0..7), at consecutive ascending addresses in consecutive cycles.
- R9: After reset, `res_valid`, `res_trap`, `mem_rd_en` and `busy` are low and `res_data` is zero.
- R10: `res_valid` and `res_trap` are never high together, and each is a single-cycle pulse. A request presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_addr | input | 32 | Dynamic byte address |
| req_offset | input | 32 | Static byte offset |
| req_kind | input | 3 | Load kind 0..7 |
| req_signed | input | 1 | Sign-extend widening loads |
| mem_size | input | 33 | Current memory size in bytes |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 32 | Memory read byte address |
| mem_rd_data | input | 8 | Read byte, valid the cycle after the strobe |
| busy | output | 1 | Access in progress |
| res_valid | output | 1 | Result pulse |
| res_data | output | 128 | Result vector |
| res_trap | output | 1 | Out-of-bounds pulse |

## Verification
The hardest cases to reach are the bounds limits. These are an access ending exactly on the memory size, one ending a byte past it, and a sum of address and offset that carries into bit 32. Random addresses almost never land on these points. Directed requests therefore place the access at `mem_size` minus its length, and at that point plus one, for several kinds. They also pair an address near the top of the 32-bit space with a large offset, and use a memory size of exactly 2^32. Random requests then mix all kinds, both signedness values and addresses scattered around a small memory edge, so that traps and legal loads interleave.

// File: rtl/vload_pkg.sv
package vload_pkg;

   typedef enum logic [2:0] {
      LK_FULL  = 3'd0,
      LK_WID8  = 3'd1,
      LK_WID16 = 3'd2,
      LK_WID32 = 3'd3,
      LK_BC8   = 3'd4,
      LK_BC16  = 3'd5,
      LK_BC32  = 3'd6,
      LK_BC64  = 3'd7
   } load_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_READ,
      ST_DRAIN,
      ST_FORM
   } load_state_e;

   // number of bytes fetched by a kind for a vector of vec_bytes bytes
   function automatic int unsigned kind_len(load_kind_e k, int unsigned vec_bytes);
      case (k)
         LK_FULL:                    return vec_bytes;
         LK_WID8, LK_WID16, LK_WID32: return vec_bytes / 2;
         LK_BC8:                     return 1;
         LK_BC16:                    return 2;
         LK_BC32:                    return 4;
         default:                    return 8;
      endcase
   endfunction

endpackage

// File: rtl/vload_addr_check.sv
module vload_addr_check #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 5
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] offset,
   input  logic [LEN_W-1:0]  len,
   input  logic [ADDR_W:0]   mem_size,
   output logic [ADDR_W:0]   eff_addr,
   output logic              oob
);
   localparam int EXT_W = ADDR_W + 2;

   logic [EXT_W-1:0] end_addr;

   always_comb begin
      eff_addr = {1'b0, base} + {1'b0, offset};
      end_addr = {1'b0, eff_addr} + EXT_W'(len);
      oob      = end_addr > {1'b0, mem_size};
   end
endmodule

// File: rtl/vload_byte_collect.sv
module vload_byte_collect #(
   parameter int NBYTES = 16,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              cap_en,
   input  logic [IDX_W-1:0]  cap_idx,
   input  logic [7:0]        din,
   output logic [NBYTES*8-1:0] raw
);
   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            raw[b*8 +: 8] <= '0;
         else if (clear)
            raw[b*8 +: 8] <= '0;
         else if (cap_en && (cap_idx == IDX_W'(b)))
            raw[b*8 +: 8] <= din;
      end
   end
endmodule

// File: rtl/vload_format.sv
module vload_format
   import vload_pkg::*;
#(
   parameter int VEC_W = 128
) (
   input  load_kind_e       kind,
   input  logic             sext,
   input  logic [VEC_W-1:0] raw,
   output logic [VEC_W-1:0] vec
);
   localparam int NB = VEC_W / 8;

   logic [VEC_W-1:0] wid [3];
   logic [VEC_W-1:0] bc  [4];

   // widening variants: element width 8 << w, lane width twice that
   for (genvar w = 0; w < 3; w++) begin : g_wid
      localparam int EW = 8 << w;
      localparam int NL = VEC_W / (2 * EW);
      always_comb begin
         wid[w] = '0;
         for (int i = 0; i < NL; i++)
            wid[w][i*2*EW +: 2*EW] = {{EW{sext & raw[i*EW + EW - 1]}}, raw[i*EW +: EW]};
      end
   end

   // broadcast variants: element width 8 << s
   for (genvar s = 0; s < 4; s++) begin : g_bc
      localparam int EW = 8 << s;
      always_comb begin
         bc[s] = '0;
         for (int i = 0; i < VEC_W / EW; i++)
            bc[s][i*EW +: EW] = raw[EW-1:0];
      end
   end

   always_comb begin
      case (kind)
         LK_FULL:  vec = raw;
         LK_WID8:  vec = wid[0];
         LK_WID16: vec = wid[1];
         LK_WID32: vec = wid[2];
         LK_BC8:   vec = bc[0];
         LK_BC16:  vec = bc[1];
         LK_BC32:  vec = bc[2];
         default:  vec = bc[3];
      endcase
   end

   logic unused_hi;
   assign unused_hi = ^NB;
endmodule

// File: rtl/vec_load_unit.sv
module vec_load_unit
   import vload_pkg::*;
#(
   parameter int VEC_W  = 128,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ADDR_W-1:0] req_offset,
   input  logic [2:0]        req_kind,
   input  logic              req_signed,
   input  logic [ADDR_W:0]   mem_size,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [7:0]        mem_rd_data,
   output logic              busy,
   output logic              res_valid,
   output logic [VEC_W-1:0]  res_data,
   output logic              res_trap
);
   localparam int VEC_BYTES = VEC_W / 8;
   localparam int IDX_W     = $clog2(VEC_BYTES);
   localparam int LEN_W     = $clog2(VEC_BYTES + 1);

   if (VEC_W % 64 != 0 || VEC_W < 64) begin : g_bad_width
      $error("VEC_W must be a positive multiple of 64");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W too small");
   end

   load_state_e      state;
   load_kind_e       kind_in, kind_q;
   logic             sext_q;
   logic [ADDR_W:0]  ea_now, ea_q;
   logic             oob_now;
   logic [LEN_W-1:0] len_now, len_q;
   logic [IDX_W-1:0] cnt;
   logic             cap_en;
   logic [IDX_W-1:0] cap_idx;
   logic             accept;
   logic [VEC_W-1:0] raw, vec;

   assign kind_in = load_kind_e'(req_kind);
   assign len_now = LEN_W'(kind_len(kind_in, VEC_BYTES));
   assign accept  = req_valid && (state == ST_IDLE);
   assign busy    = (state != ST_IDLE);

   vload_addr_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
      .base     (req_addr),
      .offset   (req_offset),
      .len      (len_now),
      .mem_size (mem_size),
      .eff_addr (ea_now),
      .oob      (oob_now)
   );

   assign mem_rd_en   = (state == ST_READ);
   assign mem_rd_addr = ea_q[ADDR_W-1:0] + ADDR_W'(cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_en  <= 1'b0;
         cap_idx <= '0;
      end else begin
         cap_en  <= mem_rd_en;
         cap_idx <= cnt;
      end
   end

   vload_byte_collect #(.NBYTES(VEC_BYTES), .IDX_W(IDX_W)) u_collect (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .cap_en  (cap_en),
      .cap_idx (cap_idx),
      .din     (mem_rd_data),
      .raw     (raw)
   );

   vload_format #(.VEC_W(VEC_W)) u_format (
      .kind (kind_q),
      .sext (sext_q),
      .raw  (raw),
      .vec  (vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         kind_q    <= LK_FULL;
         sext_q    <= 1'b0;
         ea_q      <= '0;
         len_q     <= '0;
         cnt       <= '0;
         res_valid <= 1'b0;
         res_trap  <= 1'b0;
         res_data  <= '0;
      end else begin
         res_valid <= 1'b0;
         res_trap  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  if (oob_now) begin
                     res_trap <= 1'b1;
                     res_data <= '0;
                  end else begin
                     kind_q <= kind_in;
                     sext_q <= req_signed;
                     ea_q   <= ea_now;
                     len_q  <= len_now;
                     cnt    <= '0;
                     state  <= ST_READ;
                  end
               end
            end
            ST_READ: begin
               if (LEN_W'(cnt) == len_q - LEN_W'(1))
                  state <= ST_DRAIN;
               else
                  cnt <= cnt + IDX_W'(1);
            end
            ST_DRAIN: state <= ST_FORM;
            default: begin
               res_valid <= 1'b1;
               res_data  <= vec;
               state     <= ST_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/vload_checker.sv
module vload_checker #(
   parameter int VEC_W  = 128,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              mem_rd_en,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              busy,
   input logic              res_valid,
   input logic [VEC_W-1:0]  res_data,
   input logic              res_trap
);
   // R10
   excl_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_valid && res_trap));

   // R10
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R7
   trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_trap |=> !res_trap || $past(req_valid));

   // R7
   trap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_trap |-> (res_data == '0));

   // R7
   trap_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_trap |-> !mem_rd_en);

   // R8
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + 1'b1));

   // R8
   read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> busy);

   // R10
   idle_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !busy);
endmodule

bind vec_load_unit vload_checker #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_vload_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .mem_rd_en   (mem_rd_en),
   .mem_rd_addr (mem_rd_addr),
   .busy        (busy),
   .res_valid   (res_valid),
   .res_data    (res_data),
   .res_trap    (res_trap)
);

// File: tb/test_vec_load_unit.sv
module test_vec_load_unit;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [31:0]  req_addr = '0;
   logic [31:0]  req_offset = '0;
   logic [2:0]   req_kind = '0;
   logic         req_signed = 1'b0;
   logic [32:0]  mem_size = '0;
   logic         mem_rd_en;
   logic [31:0]  mem_rd_addr;
   logic [7:0]   mem_rd_data = '0;
   logic         busy;
   logic         res_valid;
   logic [127:0] res_data;
   logic         res_trap;

   int checks = 0;
   int fails  = 0;
   int rd_count = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_load_unit i_vec_load_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_offset(req_offset), .req_kind(req_kind), .req_signed(req_signed),
      .mem_size(mem_size), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_data(mem_rd_data), .busy(busy), .res_valid(res_valid),
      .res_data(res_data), .res_trap(res_trap)
   );

   function automatic logic [7:0] mbyte(logic [31:0] a);
      return a[7:0] ^ {a[10:8], a[15:11]} ^ a[23:16] ^ a[31:24] ^ 8'hA5;
   endfunction

   always @(posedge clk) begin
      mem_rd_data <= mem_rd_en ? mbyte(mem_rd_addr) : 8'h00;
      if (mem_rd_en) rd_count <= rd_count + 1;
   end

   function automatic int klen(logic [2:0] k);
      int t [8] = '{16, 8, 8, 8, 1, 2, 4, 8};
      return t[k];
   endfunction

   function automatic logic [127:0] expect_vec(logic [2:0] k, logic sg, logic [31:0] ea);
      logic [7:0] b [16];
      logic [127:0] r = '0;
      logic [63:0] e;
      for (int i = 0; i < 16; i++) b[i] = mbyte(ea + 32'(i));
      case (k)
         3'd0: for (int i = 0; i < 16; i++) r[8*i +: 8] = b[i];
         3'd1: for (int i = 0; i < 8; i++) begin
            e = {56'h0, b[i]};
            if (sg && b[i][7]) e[15:8] = 8'hFF;
            r[16*i +: 16] = e[15:0];
         end
         3'd2: for (int i = 0; i < 4; i++) begin
            e = {48'h0, b[2*i+1], b[2*i]};
            if (sg && e[15]) e[31:16] = 16'hFFFF;
            r[32*i +: 32] = e[31:0];
         end
         3'd3: for (int i = 0; i < 2; i++) begin
            e = {32'h0, b[4*i+3], b[4*i+2], b[4*i+1], b[4*i]};
            if (sg && e[31]) e[63:32] = 32'hFFFF_FFFF;
            r[64*i +: 64] = e;
         end
         default: begin
            for (int i = 0; i < 16; i++) r[8*i +: 8] = b[i % klen(k)];
         end
      endcase
      return r;
   endfunction

   task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic run_op(logic [31:0] a, logic [31:0] off, logic [2:0] k, logic sg,
                         logic [32:0] msz, string req);
      logic [33:0] ea = 34'(a) + 34'(off);
      bit exp_trap = (ea + 34'(klen(k))) > 34'(msz);
      logic [127:0] exp = exp_trap ? '0 : expect_vec(k, sg, ea[31:0]);
      int waitc = 0;
      @(negedge clk);
      rd_count   = 0;
      req_valid  = 1'b1; req_addr = a; req_offset = off;
      req_kind   = k; req_signed = sg; mem_size = msz;
      @(negedge clk);
      req_valid = 1'b0;
      while (!(res_valid || res_trap) && waitc < 60) begin
         @(negedge clk);
         waitc++;
      end
      check(res_trap == exp_trap, req, "trap", 128'(res_trap), 128'(exp_trap));
      check(res_valid == !exp_trap, req, "valid", 128'(res_valid), 128'(!exp_trap));
      check(res_data == exp, req, "data", res_data, exp);
      check(rd_count == (exp_trap ? 0 : klen(k)), exp_trap ? "R7" : "R8", "reads",
            128'(rd_count), 128'(exp_trap ? 0 : klen(k)));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [127:0] first_exp;
      process::self().srandom(32'd1234);
      repeat (3) @(negedge clk);
      // R9 reset state
      check(!res_valid && !res_trap && !mem_rd_en && !busy, "R9", "reset flags",
            {124'h0, res_valid, res_trap, mem_rd_en, busy}, '0);
      check(res_data == '0, "R9", "reset data", res_data, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 full load
      run_op(32'h100, 32'h10, 3'd0, 1'b0, 33'h1000, "R1");
      // R2 / R3 widening, both signs
      for (int k = 1; k <= 3; k++) begin
         run_op(32'h2F0, 32'h3, 3'(k), 1'b1, 33'h1000, "R3");
         run_op(32'h2F0, 32'h3, 3'(k), 1'b0, 33'h1000, "R2");
      end
      // R4 broadcasts
      for (int k = 4; k <= 7; k++) run_op(32'h7F, 32'h1, 3'(k), 1'b0, 33'h1000, "R4");
      // R6 exact end legal, one past traps
      run_op(32'hFF0, 32'h0, 3'd0, 1'b0, 33'h1000, "R6");
      run_op(32'hFF1, 32'h0, 3'd0, 1'b0, 33'h1000, "R6");
      run_op(32'hFF8, 32'h0, 3'd7, 1'b1, 33'h1000, "R6");
      run_op(32'hFF9, 32'h0, 3'd1, 1'b1, 33'h1000, "R6");
      run_op(32'hFFF, 32'h0, 3'd4, 1'b0, 33'h1000, "R6");
      // R5 33-bit sum: carry into bit 32 traps, top of 4 GiB is legal
      run_op(32'hFFFF_FFF0, 32'h20, 3'd4, 1'b0, 33'h1_0000_0000, "R5");
      run_op(32'hFFFF_FF00, 32'hF0, 3'd0, 1'b0, 33'h1_0000_0000, "R5");
      run_op(32'h8000_0000, 32'h8000_0000, 3'd4, 1'b0, 33'h1_0000_0000, "R5");
      // R7 trap with zero-size memory
      run_op(32'h0, 32'h0, 3'd4, 1'b0, 33'h0, "R7");

      // R10 request while busy is ignored
      @(negedge clk);
      first_exp = expect_vec(3'd0, 1'b0, 32'h40);
      rd_count = 0;
      req_valid = 1'b1; req_addr = 32'h40; req_offset = 0; req_kind = 3'd0;
      req_signed = 1'b0; mem_size = 33'h1000;
      @(negedge clk);
      req_addr = 32'hFFFF_0000; req_kind = 3'd7;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      while (!(res_valid || res_trap)) @(negedge clk);
      check(res_valid && !res_trap && res_data == first_exp, "R10", "busy request ignored",
            res_data, first_exp);
      @(negedge clk);
      check(!res_trap && !res_valid && !busy, "R10", "no late result",
            {125'h0, res_trap, res_valid, busy}, '0);

      // random mix around a small memory edge
      for (int n = 0; n < 300; n++) begin
         logic [31:0] a = $urandom % 32'h1100;
         logic [31:0] o = $urandom % 32'h40;
         logic [2:0]  k = 3'($urandom);
         logic        s = 1'($urandom);
         run_op(a, o, k, s, 33'h1100, k == 0 ? "R1" : (k < 4 ? "R2" : "R4"));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule